// File: doc/BRIEF.md
# Privileged Control Register Unit

This block holds the small set of privileged control registers that a processor core reaches with move-from and move-to operations. A request carries a register number, a direction and 64 bits of write data. The block checks the access against the policy of that register. A register may be read-write, read-only or write-only. Access to the kernel stack pointer also needs privileged mode. A legal access is then carried out with the semantics of that register. These include narrow fields that read back sign-extended, a nibble merge of AND and OR, write-one-to-clear bits, a register that sets one bit by index, and swap writes that return the previous value. Writes to the invalidate registers produce a one-cycle translation-buffer flush pulse.

Behaviour is organised around a response state machine with four states. ST_IDLE means no response is pending. ST_READ, ST_WRITE and ST_FAULT each present the result of the request accepted on the previous edge, for exactly one cycle. The transitions are the same from every state. A request that the policy rejects goes to ST_FAULT. A legal write goes to ST_WRITE and a legal read goes to ST_READ. A cycle without a request goes to ST_IDLE. Back-to-back requests are accepted every cycle. A machine-check event input sets the low error-summary bits.

Top module: `prr_unit`

## Requirements
- R1: While reset is asserted and after it is released, resp_valid, resp_err, tb_flush_all and tb_flush_page are 0. After reset, every stored register is 0, except the priority level, which resets to 5'h1F and therefore reads as all ones.
- R2: A request sampled at a rising edge produces resp_valid for exactly the following cycle. A cycle without a request produces no response. resp_rdata carries the read value only for legal reads and is 0 otherwise. resp_old is 0 except for legal swap writes.
- R3: Index 0 (interrupt-trap enable) and index 1 (interrupt-trap summary) are 4-bit swap registers. A write returns the old value, sign-extended from bit 3, on resp_old. It stores (old AND wdata[3:0]) OR wdata[7:4]. A read returns the value sign-extended from bit 3.
- R4: Index 4 (priority level) is a 5-bit swap register. A write returns the old value, sign-extended from bit 4, and stores wdata[4:0]. A read is sign-extended from bit 4.
- R5: Index 6 (machine-check summary) is 5 bits wide. A write clears the bits of [2:0] that are set in wdata[2:0] and loads bits [4:3] from wdata[4:3]. A mchk_event bit sets the matching bit of [2:0] in the same cycle, and a set beats a clear. A read is sign-extended from bit 4.
- R6: A write to index 11 (software interrupt request) with wdata[3:0] = N, where N is nonzero, sets bit N of the 16-bit software interrupt summary at index 12. A write with N = 0 changes nothing. Index 12 reads sign-extended from bit 15.
- R7: The following registers store and read back as listed. Index 2 (FP enable) stores wdata[0] and reads sign-extended from bit 0. Index 10 (system control base) stores wdata[31:0] and reads sign-extended from bit 31. Index 7 (control block base) reads the parameter CB_BASE_INIT sign-extended from bit 47. Indices 8, 13 and 5 are full 64-bit read-write registers. Indices 9, 14 and 20 read their parameter values unchanged.
- R8: A write to a read-only index (7, 9, 12, 14 or 20) raises resp_err.
- R9: A read of a write-only index (3, 11, 15, 16, 17, 18 or 19) raises resp_err. A legal write to index 3 has no effect.
- R10: A write to index 15 or 16 pulses tb_flush_all for one cycle. A write to index 17, 18 or 19 pulses tb_flush_page for one cycle, with tb_page_addr equal to wdata in that cycle. The two pulses are never high together.
- R11: Index 5 (kernel stack) is accessible only while priv_mode is 1. Any access to it with priv_mode at 0 raises resp_err.
- R12: Indices 21 to 63 raise resp_err on any access. A faulted request changes no register, gives resp_rdata = 0 and resp_old = 0, and produces no flush pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_idx | input | 6 | Register number |
| req_wdata | input | 64 | Write data |
| priv_mode | input | 1 | Current mode is privileged |
| mchk_event | input | 3 | Machine-check events to record |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_err | output | 1 | Request rejected by policy |
| resp_rdata | output | 64 | Read value |
| resp_old | output | 64 | Pre-write value of swap registers |
| tb_flush_all | output | 1 | Full translation-buffer flush pulse |
| tb_flush_page | output | 1 | Single-page flush pulse |
| tb_page_addr | output | 64 | Address for the page flush |

## Verification
The embedded assertions check on every cycle that the two flush pulses never overlap. They also check that a response only follows a request, that a faulted response carries no data and no flush, and that stored fields hold while no legal write occurs. They confirm that the software interrupt summary only gains bits. The exact values are shown only by the bench's scenarios, which compare against a register model. These cover the merge arithmetic, the swap old values, the sign-extension boundaries, the set-beats-clear race on the machine-check bits, the index-zero request that must not set a bit, and the privilege and direction faults.

// File: rtl/prr_pkg.sv
package prr_pkg;
    localparam int DATA_W = 64;
    localparam int IDX_W  = 6;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam idx_t IX_AST_EN    = 6'd0;
    localparam idx_t IX_AST_SUM   = 6'd1;
    localparam idx_t IX_FP_EN     = 6'd2;
    localparam idx_t IX_IRQ_SEND  = 6'd3;
    localparam idx_t IX_PRIO      = 6'd4;
    localparam idx_t IX_KSTACK    = 6'd5;
    localparam idx_t IX_MCHK      = 6'd6;
    localparam idx_t IX_CB_BASE   = 6'd7;
    localparam idx_t IX_PROC_BASE = 6'd8;
    localparam idx_t IX_PT_BASE   = 6'd9;
    localparam idx_t IX_SCB_BASE  = 6'd10;
    localparam idx_t IX_SWI_REQ   = 6'd11;
    localparam idx_t IX_SWI_SUM   = 6'd12;
    localparam idx_t IX_VPT_BASE  = 6'd13;
    localparam idx_t IX_CPU_ID    = 6'd14;
    localparam idx_t IX_INV_ALL   = 6'd15;
    localparam idx_t IX_INV_ALLP  = 6'd16;
    localparam idx_t IX_INV_ONE   = 6'd17;
    localparam idx_t IX_INV_ONE_D = 6'd18;
    localparam idx_t IX_INV_ONE_I = 6'd19;
    localparam idx_t IX_ASID      = 6'd20;

    typedef enum logic [1:0] {ACC_RW, ACC_RO, ACC_WO, ACC_NONE} acc_e;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FAULT} resp_st_e;

    function automatic word_t sext_at(input word_t v, input int msb);
        word_t r;
        for (int i = 0; i < DATA_W; i++)
            r[i] = (i <= msb) ? v[i] : v[msb];
        return r;
    endfunction
endpackage

// File: rtl/prr_policy.sv
module prr_policy
    import prr_pkg::*;
(
    input  idx_t idx,
    input  logic wr,
    input  logic priv,
    output logic fault,
    output logic hit_all,
    output logic hit_page
);
    acc_e acc;

    always_comb begin
        unique case (idx)
            IX_AST_EN, IX_AST_SUM, IX_FP_EN, IX_PRIO, IX_KSTACK, IX_MCHK,
            IX_PROC_BASE, IX_SCB_BASE, IX_VPT_BASE:              acc = ACC_RW;
            IX_CB_BASE, IX_PT_BASE, IX_SWI_SUM, IX_CPU_ID, IX_ASID: acc = ACC_RO;
            IX_IRQ_SEND, IX_SWI_REQ, IX_INV_ALL, IX_INV_ALLP,
            IX_INV_ONE, IX_INV_ONE_D, IX_INV_ONE_I:              acc = ACC_WO;
            default:                                             acc = ACC_NONE;
        endcase
    end

    always_comb begin
        fault = (acc == ACC_NONE) || (wr && acc == ACC_RO) || (!wr && acc == ACC_WO)
              || (idx == IX_KSTACK && !priv);
        hit_all  = (idx == IX_INV_ALL) || (idx == IX_INV_ALLP);
        hit_page = (idx == IX_INV_ONE) || (idx == IX_INV_ONE_D) || (idx == IX_INV_ONE_I);
    end
endmodule

// File: rtl/prr_regs.sv
module prr_regs
    import prr_pkg::*;
#(
    parameter word_t CB_BASE_INIT = 64'h0000_8000_0000_1000,
    parameter word_t PT_BASE_INIT = 64'h0000_0000_0004_2000,
    parameter word_t CPU_ID       = 64'd3,
    parameter word_t ASID_INIT    = 64'd0
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  idx_t       idx,
    input  word_t      wdata,
    input  logic [2:0] mchk_event,
    output word_t      rd_view,
    output word_t      old_view
);
    logic [3:0]  ast_en_q, ast_sum_q;
    logic        fen_q;
    logic [4:0]  ipl_q, mces_q;
    logic [15:0] sisr_q;
    logic [31:0] scbb_q;
    word_t       ksp_q, prbr_q, vptb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ast_en_q  <= '0;
            ast_sum_q <= '0;
            fen_q     <= 1'b0;
            ipl_q     <= 5'h1F;
            mces_q    <= '0;
            sisr_q    <= '0;
            scbb_q    <= '0;
            ksp_q     <= '0;
            prbr_q    <= '0;
            vptb_q    <= '0;
        end else begin
            mces_q[2:0] <= mces_q[2:0] | mchk_event;
            if (wr_en) begin
                unique case (idx)
                    IX_AST_EN:    ast_en_q  <= (ast_en_q & wdata[3:0]) | wdata[7:4];
                    IX_AST_SUM:   ast_sum_q <= (ast_sum_q & wdata[3:0]) | wdata[7:4];
                    IX_FP_EN:     fen_q     <= wdata[0];
                    IX_PRIO:      ipl_q     <= wdata[4:0];
                    IX_KSTACK:    ksp_q     <= wdata;
                    IX_MCHK:      mces_q    <= {wdata[4:3], (mces_q[2:0] & ~wdata[2:0]) | mchk_event};
                    IX_PROC_BASE: prbr_q    <= wdata;
                    IX_SCB_BASE:  scbb_q    <= wdata[31:0];
                    IX_SWI_REQ:   if (wdata[3:0] != 4'd0) sisr_q[wdata[3:0]] <= 1'b1;
                    IX_VPT_BASE:  vptb_q    <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (idx)
            IX_AST_EN:    rd_view = sext_at({60'd0, ast_en_q}, 3);
            IX_AST_SUM:   rd_view = sext_at({60'd0, ast_sum_q}, 3);
            IX_FP_EN:     rd_view = sext_at({63'd0, fen_q}, 0);
            IX_PRIO:      rd_view = sext_at({59'd0, ipl_q}, 4);
            IX_KSTACK:    rd_view = ksp_q;
            IX_MCHK:      rd_view = sext_at({59'd0, mces_q}, 4);
            IX_CB_BASE:   rd_view = sext_at(CB_BASE_INIT, 47);
            IX_PROC_BASE: rd_view = prbr_q;
            IX_PT_BASE:   rd_view = PT_BASE_INIT;
            IX_SCB_BASE:  rd_view = sext_at({32'd0, scbb_q}, 31);
            IX_SWI_SUM:   rd_view = sext_at({48'd0, sisr_q}, 15);
            IX_VPT_BASE:  rd_view = vptb_q;
            IX_CPU_ID:    rd_view = CPU_ID;
            IX_ASID:      rd_view = ASID_INIT;
            default:      rd_view = '0;
        endcase
        old_view = (idx == IX_AST_EN || idx == IX_AST_SUM || idx == IX_PRIO) ? rd_view : '0;
    end

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({ast_en_q, ast_sum_q, ipl_q, fen_q, ksp_q, scbb_q, vptb_q, prbr_q, sisr_q}));
    // R6
    sisr_grow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sisr_q & $past(sisr_q)) == $past(sisr_q)));
endmodule

// File: rtl/prr_unit.sv
module prr_unit
    import prr_pkg::*;
#(
    parameter word_t CB_BASE_INIT = 64'h0000_8000_0000_1000,
    parameter word_t PT_BASE_INIT = 64'h0000_0000_0004_2000,
    parameter word_t CPU_ID       = 64'd3,
    parameter word_t ASID_INIT    = 64'd0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              priv_mode,
    input  logic [2:0]        mchk_event,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [DATA_W-1:0] resp_old,
    output logic              tb_flush_all,
    output logic              tb_flush_page,
    output logic [DATA_W-1:0] tb_page_addr
);
    resp_st_e state_q, state_d;
    logic  fault, hit_all, hit_page, legal_wr, legal_rd;
    word_t rd_view, old_view;
    word_t rdata_q, old_q, page_q;
    logic  all_q, one_q;

    prr_policy u_policy (
        .idx(req_idx), .wr(req_write), .priv(priv_mode),
        .fault(fault), .hit_all(hit_all), .hit_page(hit_page)
    );

    prr_regs #(
        .CB_BASE_INIT(CB_BASE_INIT), .PT_BASE_INIT(PT_BASE_INIT),
        .CPU_ID(CPU_ID), .ASID_INIT(ASID_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(legal_wr), .idx(req_idx),
        .wdata(req_wdata), .mchk_event(mchk_event),
        .rd_view(rd_view), .old_view(old_view)
    );

    assign legal_wr = req_valid && !fault && req_write;
    assign legal_rd = req_valid && !fault && !req_write;

    always_comb begin
        if (!req_valid)     state_d = ST_IDLE;
        else if (fault)     state_d = ST_FAULT;
        else if (req_write) state_d = ST_WRITE;
        else                state_d = ST_READ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            old_q   <= '0;
            page_q  <= '0;
            all_q   <= 1'b0;
            one_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rdata_q <= legal_rd ? rd_view : '0;
            old_q   <= legal_wr ? old_view : '0;
            all_q   <= legal_wr && hit_all;
            one_q   <= legal_wr && hit_page;
            page_q  <= (legal_wr && hit_page) ? req_wdata : '0;
        end
    end

    always_comb begin
        resp_valid    = 1'b0;
        resp_err      = 1'b0;
        resp_rdata    = '0;
        resp_old      = '0;
        tb_flush_all  = 1'b0;
        tb_flush_page = 1'b0;
        tb_page_addr  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                resp_valid = 1'b1;
                resp_rdata = rdata_q;
            end
            ST_WRITE: begin
                resp_valid    = 1'b1;
                resp_old      = old_q;
                tb_flush_all  = all_q;
                tb_flush_page = one_q;
                tb_page_addr  = page_q;
            end
            ST_FAULT: begin
                resp_valid = 1'b1;
                resp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    flush_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tb_flush_all, tb_flush_page}));
    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    // R12
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (!tb_flush_all && !tb_flush_page && resp_rdata == '0 && resp_old == '0));
    // R11
    kstack_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_idx == IX_KSTACK && !priv_mode) |=> resp_err);
endmodule

// File: tb/prr_unit_bench.sv
module prr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, priv_mode = 1'b1;
    logic [5:0]  req_idx = '0;
    logic [63:0] req_wdata = '0;
    logic [2:0]  mchk_event = '0;
    logic        resp_valid, resp_err, tb_flush_all, tb_flush_page;
    logic [63:0] resp_rdata, resp_old, tb_page_addr;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    localparam logic [63:0] CB_P = 64'h0000_8000_0000_1000;
    localparam logic [63:0] PT_P = 64'h0000_0000_0004_2000;
    localparam logic [63:0] ID_P = 64'd3;

    always #10 clk = ~clk;

    prr_unit u_prr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .priv_mode(priv_mode),
        .mchk_event(mchk_event), .resp_valid(resp_valid), .resp_err(resp_err),
        .resp_rdata(resp_rdata), .resp_old(resp_old), .tb_flush_all(tb_flush_all),
        .tb_flush_page(tb_flush_page), .tb_page_addr(tb_page_addr)
    );

    // register model
    logic [3:0]  m_aen, m_asum;
    logic        m_fen;
    logic [4:0]  m_ipl, m_mces;
    logic [15:0] m_sisr;
    logic [31:0] m_scb;
    logic [63:0] m_ksp, m_prb, m_vpt;

    function automatic logic [63:0] sx(input logic [63:0] v, input int msb);
        logic [63:0] r = v;
        for (int i = msb + 1; i < 64; i++) r[i] = v[msb];
        return r;
    endfunction

    function automatic bit is_ro(input logic [5:0] ix);
        return ix == 7 || ix == 9 || ix == 12 || ix == 14 || ix == 20;
    endfunction
    function automatic bit is_wo(input logic [5:0] ix);
        return ix == 3 || ix == 11 || (ix >= 15 && ix <= 19);
    endfunction

    function automatic bit exp_fault(input bit wr, input logic [5:0] ix, input bit pv);
        if (ix > 20) return 1;
        if (wr && is_ro(ix)) return 1;
        if (!wr && is_wo(ix)) return 1;
        if (ix == 5 && !pv) return 1;
        return 0;
    endfunction

    function automatic logic [63:0] exp_read(input logic [5:0] ix);
        case (ix)
            0: return sx({60'd0, m_aen}, 3);
            1: return sx({60'd0, m_asum}, 3);
            2: return sx({63'd0, m_fen}, 0);
            4: return sx({59'd0, m_ipl}, 4);
            5: return m_ksp;
            6: return sx({59'd0, m_mces}, 4);
            7: return sx(CB_P, 47);
            8: return m_prb;
            9: return PT_P;
            10: return sx({32'd0, m_scb}, 31);
            12: return sx({48'd0, m_sisr}, 15);
            13: return m_vpt;
            14: return ID_P;
            20: return 64'd0;
            default: return 64'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_aen = 0; m_asum = 0; m_fen = 0; m_ipl = 5'h1F; m_mces = 0;
        m_sisr = 0; m_scb = 0; m_ksp = 0; m_prb = 0; m_vpt = 0;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one request and check its response; tag names the requirement
    task automatic op(input bit wr, input logic [5:0] ix, input logic [63:0] wd,
                      input bit pv, input logic [2:0] ev, input string tag);
        bit f;
        logic [63:0] e_rd, e_old;
        bit e_all, e_one;
        f = exp_fault(wr, ix, pv);
        e_rd = (!f && !wr) ? exp_read(ix) : 64'd0;
        e_old = (!f && wr && (ix == 0 || ix == 1 || ix == 4)) ? exp_read(ix) : 64'd0;
        e_all = !f && wr && (ix == 15 || ix == 16);
        e_one = !f && wr && (ix >= 17 && ix <= 19);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_idx = ix; req_wdata = wd;
        priv_mode = pv; mchk_event = ev;
        // model update at the edge
        m_mces[2:0] = m_mces[2:0] | ev;
        if (!f && wr) begin
            case (ix)
                0: m_aen = (m_aen & wd[3:0]) | wd[7:4];
                1: m_asum = (m_asum & wd[3:0]) | wd[7:4];
                2: m_fen = wd[0];
                4: m_ipl = wd[4:0];
                5: m_ksp = wd;
                6: m_mces = {wd[4:3], (m_mces[2:0] & ~wd[2:0]) | ev};
                8: m_prb = wd;
                10: m_scb = wd[31:0];
                11: if (wd[3:0] != 0) m_sisr[wd[3:0]] = 1'b1;
                13: m_vpt = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 0; mchk_event = 0;
        chk(resp_valid === 1'b1, {tag, " R2 valid"}, {63'd0, resp_valid}, 64'd1);
        chk(resp_err === f, {tag, " err"}, {63'd0, resp_err}, {63'd0, f});
        chk(resp_rdata === e_rd, {tag, " rdata"}, resp_rdata, e_rd);
        chk(resp_old === e_old, {tag, " old"}, resp_old, e_old);
        chk(tb_flush_all === e_all && tb_flush_page === e_one, {tag, " R10 flush"},
            {62'd0, tb_flush_all, tb_flush_page}, {62'd0, e_all, e_one});
        chk(tb_page_addr === (e_one ? wd : 64'd0), {tag, " R10 addr"}, tb_page_addr, e_one ? wd : 64'd0);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        chk(resp_valid === 1'b0 && tb_flush_all === 1'b0 && tb_flush_page === 1'b0,
            tag, {61'd0, resp_valid, tb_flush_all, tb_flush_page}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        chk(resp_valid === 0 && resp_err === 0 && tb_flush_all === 0 && tb_flush_page === 0,
            "R1 reset outputs", {60'd0, resp_valid, resp_err, tb_flush_all, tb_flush_page}, 64'd0);
        rst_n = 1;
        idle_check("R1 idle after reset");
        idle_check("R2 no request no response");
        op(0, 4, 0, 1, 0, "R1 ipl reset");
        op(0, 0, 0, 1, 0, "R1 ast reset");
        // R3 merge and swap
        op(1, 0, 64'h5A, 1, 0, "R3 ast_en set");
        op(1, 0, 64'h06, 1, 0, "R3 ast_en and");
        op(0, 0, 0, 1, 0, "R3 ast_en read");
        op(1, 1, 64'h8F, 1, 0, "R3 ast_sum");
        op(0, 1, 0, 1, 0, "R3 ast_sum read");
        // R4
        op(1, 4, 64'hFFFF_FFFF_FFFF_FFE7, 1, 0, "R4 ipl swap");
        op(1, 4, 64'h0F, 1, 0, "R4 ipl positive");
        op(0, 4, 0, 1, 0, "R4 ipl read");
        // R5
        op(0, 6, 0, 1, 3'b101, "R5 event pending");
        op(0, 6, 0, 1, 0, "R5 event seen");
        op(1, 6, 64'h11, 1, 3'b001, "R5 set beats clear");
        op(0, 6, 0, 1, 0, "R5 read");
        op(1, 6, 64'h05, 1, 0, "R5 clear");
        op(0, 6, 0, 1, 0, "R5 read cleared");
        // R6
        op(1, 11, 64'h0, 1, 0, "R6 index zero");
        op(0, 12, 0, 1, 0, "R6 sum unchanged");
        op(1, 11, 64'hF, 1, 0, "R6 top bit");
        op(1, 11, 64'h3, 1, 0, "R6 bit3");
        op(0, 12, 0, 1, 0, "R6 sum read");
        // R7
        op(1, 2, 64'h3, 1, 0, "R7 fen");
        op(0, 2, 0, 1, 0, "R7 fen read");
        op(1, 10, 64'h1234_5678_8000_0001, 1, 0, "R7 scb");
        op(0, 10, 0, 1, 0, "R7 scb read");
        op(0, 7, 0, 1, 0, "R7 cb base");
        op(0, 9, 0, 1, 0, "R7 pt base");
        op(0, 14, 0, 1, 0, "R7 cpu id");
        // R8, R9
        op(1, 12, 64'hFFFF, 1, 0, "R8 ro write");
        op(0, 12, 0, 1, 0, "R8 sum intact");
        op(1, 7, 64'h1, 1, 0, "R8 cb write");
        op(0, 17, 0, 1, 0, "R9 wo read");
        op(1, 3, 64'hFF, 1, 0, "R9 irq send");
        // R10
        op(1, 15, 64'h77, 1, 0, "R10 inv all");
        op(1, 18, 64'hDEAD_BEEF_0000_2000, 1, 0, "R10 inv one");
        idle_check("R10 pulse ends");
        // R11
        op(1, 5, 64'hCAFE, 0, 0, "R11 ksp no priv");
        op(0, 5, 0, 1, 0, "R11 ksp priv read");
        op(1, 5, 64'hCAFE, 1, 0, "R11 ksp write");
        op(0, 5, 0, 0, 0, "R11 ksp read no priv");
        // R12
        op(1, 40, 64'h1, 1, 0, "R12 unknown write");
        op(0, 63, 0, 1, 0, "R12 unknown read");
        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [5:0] ix;
            ix = 6'($urandom % 24);
            op(1'($urandom), ix, {$urandom, $urandom}, ($urandom % 8) != 0,
               (($urandom % 6) == 0) ? 3'($urandom) : 3'd0, "R12 random");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule